// File: doc/BRIEF.md
# SPI Radio Wake-Up and Identity Check Sequencer

This block brings a radio transceiver on an SPI link out of reset and then checks that the transceiver answers. A single `start` pulse launches a fixed sequence. Chip-select first gives a short low pulse and then a long high hold. The block then asserts chip-select again and waits for the slave's data-out line to drop, which the slave uses to signal that it is ready. Next it shifts out the reset command byte and waits for data-out to drop a second time, which marks the end of reset. After that it releases chip-select, re-asserts it, waits for ready once more, and reads the version register with a two-byte transfer.

The pulse and hold lengths are set in microseconds and converted to clock cycles from a clock-frequency parameter, rounding up. Every wait for the ready line has a timeout measured in clock cycles. The sequence ends with a one-cycle `done` pulse that carries the version value and an error flag. The error flag is set when a wait times out or when the version reads back as all ones, which is what a missing slave returns.

Top module: `radio_wake_seq`

## Requirements
- R1: While reset is held, and afterwards until `start`, `cs_n` is 1, `sclk` is 0, `mosi` is 0, `done`, `err` and `busy` are 0, and `version` is 8'h00.
- R2: After `start`, `cs_n` is low for exactly ceil(PULSE_US*CLK_KHZ/1000) cycles. It is then high for exactly ceil(HOLD_US*CLK_KHZ/1000) cycles before it falls again.
- R3: After each later fall of `cs_n`, no `sclk` edge occurs until `miso` is sampled low. `miso` is sampled once per cycle for at most TIMEOUT_CYC cycles, counted from the first cycle that `cs_n` is low. A low on the last of these samples still counts as ready.
- R4: Transfers use SPI mode 0, MSB first. `sclk` idles low and stays high for SCLK_DIV/2 cycles in each bit. `mosi` is valid at each rising edge. `sclk` never rises while `cs_n` is high.
- R5: In the second chip-select session, exactly 8 bits carrying RST_CMD are sent. `cs_n` stays low from the ready wait through the byte until `miso` is seen low again, and only then rises.
- R6: The third session sends 16 bits: VER_ADDR with bit 7 set, then 8'h00. `version` is the 8 `miso` bits sampled on rising edges 9 to 16, MSB first.
- R7: `done` is high for exactly one cycle per sequence. In that cycle `cs_n` is high and `version` and `err` are valid. `busy` is low from the following cycle.
- R8: If a sequence completes without a timeout, `err` equals 1 exactly when `version` is 8'hFF.
- R9: When any ready wait times out, `cs_n` returns high and `done` follows in the next cycle with `err` = 1 and `version` = 8'hFF. No further session is opened.
- R10: A `start` pulse while `busy` is 1 has no effect on the sequence in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to run the sequence |
| miso | input | 1 | Serial data from slave; low means ready during waits |
| cs_n | output | 1 | Active-low chip-select to the slave |
| sclk | output | 1 | Serial clock, system clock divided by SCLK_DIV |
| mosi | output | 1 | Serial data to slave |
| busy | output | 1 | High while a sequence runs |
| done | output | 1 | One-cycle end-of-sequence pulse |
| err | output | 1 | Error result, valid with `done` |
| version | output | 8 | Version byte read back, valid with `done` |

## Verification
The ready line can drop in the same cycle that a wait's timeout counter reaches its last count. In that case the ready indication wins, and the sequence must go on rather than report an error. The bench's slave model sets its ready delay to exactly TIMEOUT_CYC-1 and then to TIMEOUT_CYC, in both the pre-command wait and the pre-read wait. The result is judged at the pins. In the first case the full byte traffic must appear and the version must be correct. In the second case there must be no clock edges in that session and the error result must appear.

// File: rtl/radio_wake_pkg.sv
package radio_wake_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_PULSE, ST_HOLD, ST_RDY1, ST_CMD, ST_RDONE,
    ST_REL, ST_RDY2, ST_HDR, ST_DUM, ST_FIN
  } wake_state_e;

  // microseconds to clock cycles, rounded up
  function automatic int unsigned us_to_cycles(input int unsigned us, input int unsigned khz);
    return (us * khz + 999) / 1000;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // a register read sets bit 7 of the header byte
  function automatic logic [7:0] read_header(input logic [7:0] addr);
    return addr | 8'h80;
  endfunction

endpackage

// File: rtl/wake_timer.sv
module wake_timer #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic [W-1:0] lim_m1,
  output logic         at_last
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (clear)
      cnt <= '0;
    else if (cnt != {W{1'b1}})
      cnt <= cnt + 1'b1;
  end

  assign at_last = (cnt == lim_m1);
endmodule

// File: rtl/spi_mode0_shifter.sv
module spi_mode0_shifter #(
  parameter int DIV = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       launch,
  input  logic [7:0] tx,
  input  logic       miso,
  output logic       sclk,
  output logic       mosi,
  output logic       busy,
  output logic       byte_done,
  output logic [7:0] rx
);
  localparam int PH_W = $clog2(DIV);
  localparam int HALF = DIV / 2;

  logic [PH_W-1:0] phase;
  logic [2:0]      bitn;
  logic [7:0]      txs, rxs;
  logic            busy_q, done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= '0;
      bitn   <= '0;
      txs    <= '0;
      rxs    <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (launch) begin
          busy_q <= 1'b1;
          txs    <= tx;
          phase  <= '0;
          bitn   <= '0;
        end
      end else begin
        phase <= (phase == PH_W'(DIV - 1)) ? '0 : phase + 1'b1;
        // rising edge follows this cycle: capture slave data
        if (phase == PH_W'(HALF - 1))
          rxs <= {rxs[6:0], miso};
        // falling edge follows this cycle: present next bit
        if (phase == PH_W'(DIV - 1)) begin
          txs  <= {txs[6:0], 1'b0};
          bitn <= bitn + 1'b1;
          if (bitn == 3'd7) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end
        end
      end
    end
  end

  assign sclk      = busy_q && (phase >= PH_W'(HALF));
  assign mosi      = busy_q && txs[7];
  assign busy      = busy_q;
  assign byte_done = done_q;
  assign rx        = rxs;
endmodule

// File: rtl/radio_wake_seq.sv
module radio_wake_seq
  import radio_wake_pkg::*;
#(
  parameter int unsigned CLK_KHZ     = 250_000,
  parameter int unsigned PULSE_US    = 10,
  parameter int unsigned HOLD_US     = 40,
  parameter int unsigned TIMEOUT_CYC = 4096,
  parameter int unsigned SCLK_DIV    = 16,
  parameter logic [7:0]  RST_CMD     = 8'h30,
  parameter logic [7:0]  VER_ADDR    = 8'h31
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       miso,
  output logic       cs_n,
  output logic       sclk,
  output logic       mosi,
  output logic       busy,
  output logic       done,
  output logic       err,
  output logic [7:0] version
);
  localparam int unsigned T_PULSE = us_to_cycles(PULSE_US, CLK_KHZ);
  localparam int unsigned T_HOLD  = us_to_cycles(HOLD_US, CLK_KHZ);
  localparam int unsigned T_MAX   = max2(max2(T_PULSE, T_HOLD), TIMEOUT_CYC);
  localparam int          CNT_W   = $clog2(T_MAX + 1);

  wake_state_e st, nxt;
  logic [CNT_W-1:0] lim_m1;
  logic tmr_last, tmr_clr;
  logic sh_launch, sh_busy, sh_done;
  logic [7:0] sh_tx, sh_rx;
  logic [7:0] ver_q;
  logic err_q;

  // named events for the checker
  logic in_wait, ready_seen, wait_timeout, in_byte;
  assign in_wait      = (st == ST_RDY1) || (st == ST_RDONE) || (st == ST_RDY2);
  assign ready_seen   = in_wait && !miso;
  assign wait_timeout = in_wait && miso && tmr_last;
  assign in_byte      = (st == ST_CMD) || (st == ST_HDR) || (st == ST_DUM);

  always_comb begin
    nxt = st;
    unique case (st)
      ST_IDLE:  if (start) nxt = ST_PULSE;
      ST_PULSE: if (tmr_last) nxt = ST_HOLD;
      ST_HOLD:  if (tmr_last) nxt = ST_RDY1;
      ST_RDY1:  if (ready_seen) nxt = ST_CMD;  else if (wait_timeout) nxt = ST_FIN;
      ST_CMD:   if (sh_done) nxt = ST_RDONE;
      ST_RDONE: if (ready_seen) nxt = ST_REL;  else if (wait_timeout) nxt = ST_FIN;
      ST_REL:   nxt = ST_RDY2;
      ST_RDY2:  if (ready_seen) nxt = ST_HDR;  else if (wait_timeout) nxt = ST_FIN;
      ST_HDR:   if (sh_done) nxt = ST_DUM;
      ST_DUM:   if (sh_done) nxt = ST_FIN;
      ST_FIN:   nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_comb begin
    unique case (st)
      ST_PULSE: lim_m1 = CNT_W'(T_PULSE - 1);
      ST_HOLD:  lim_m1 = CNT_W'(T_HOLD - 1);
      default:  lim_m1 = CNT_W'(TIMEOUT_CYC - 1);
    endcase
  end

  always_comb begin
    unique case (st)
      ST_HDR:  sh_tx = read_header(VER_ADDR);
      ST_DUM:  sh_tx = 8'h00;
      default: sh_tx = RST_CMD;
    endcase
  end

  assign tmr_clr   = (nxt != st);
  assign sh_launch = in_byte && !sh_busy && !sh_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      ver_q <= 8'h00;
      err_q <= 1'b0;
    end else begin
      st <= nxt;
      if (wait_timeout) begin
        ver_q <= 8'hFF;
        err_q <= 1'b1;
      end else if (st == ST_DUM && sh_done) begin
        ver_q <= sh_rx;
        err_q <= (sh_rx == 8'hFF);
      end
    end
  end

  wake_timer #(.W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .clear(tmr_clr), .lim_m1(lim_m1), .at_last(tmr_last)
  );

  spi_mode0_shifter #(.DIV(SCLK_DIV)) u_shift (
    .clk(clk), .rst_n(rst_n), .launch(sh_launch), .tx(sh_tx), .miso(miso),
    .sclk(sclk), .mosi(mosi), .busy(sh_busy), .byte_done(sh_done), .rx(sh_rx)
  );

  assign cs_n    = !((st == ST_PULSE) || in_wait || in_byte);
  assign busy    = (st != ST_IDLE);
  assign done    = (st == ST_FIN);
  assign err     = err_q;
  assign version = ver_q;
endmodule

// File: rtl/radio_wake_chk.sv
module radio_wake_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       cs_n,
  input logic       sclk,
  input logic       busy,
  input logic       done,
  input logic       err,
  input logic [7:0] version,
  input logic       wait_timeout
);
  // R4
  sclk_gated_chk: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> !sclk);
  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R7
  done_cs_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> cs_n);
  // R8
  ff_flags_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && version == 8'hFF) |-> err);
  // R9
  timeout_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wait_timeout |=> (done && err && version == 8'hFF));
  // R10
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && start) |=> busy);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (cs_n && !sclk));
endmodule

bind radio_wake_seq radio_wake_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .cs_n(cs_n), .sclk(sclk),
  .busy(busy), .done(done), .err(err), .version(version),
  .wait_timeout(wait_timeout)
);

// File: tb/tb_radio_wake_seq.sv
module tb_radio_wake_seq;
  localparam int KHZ  = 25_003;
  localparam int PUS  = 10;
  localparam int HUS  = 40;
  localparam int TO   = 300;
  localparam int DIV  = 16;
  localparam logic [7:0] RST  = 8'h30;
  localparam logic [7:0] ADDR = 8'h31;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, miso = 1'b1;
  logic cs_n, sclk, mosi, busy, done, err;
  logic [7:0] version;

  always #2 clk = ~clk;

  radio_wake_seq #(
    .CLK_KHZ(KHZ), .PULSE_US(PUS), .HOLD_US(HUS), .TIMEOUT_CYC(TO),
    .SCLK_DIV(DIV), .RST_CMD(RST), .VER_ADDR(ADDR)
  ) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .miso(miso), .cs_n(cs_n),
    .sclk(sclk), .mosi(mosi), .busy(busy), .done(done), .err(err), .version(version)
  );

  int n_chk = 0, n_fail = 0;

  function automatic int exp_cyc(input int us);
    int prod;
    prod = us * KHZ;
    return prod / 1000 + ((prod % 1000) != 0 ? 1 : 0);
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // slave model and pin monitor
  int sess, t, tr, rises, falls, hi_len, lo1, hi_gap, viol, bad_hi, rises2, rises3;
  int cfg_rdy, cfg_rst, cfg_rd;
  logic [7:0] cfg_ver, cap2;
  logic [15:0] cap3;
  logic prev_cs = 1'b1, prev_sclk = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_cs && !cs_n) begin
        sess++; t = 0; tr = 0; rises = 0; falls = 0;
      end
      if (sess == 1 && !cs_n) lo1++;
      if (sess == 1 && cs_n) hi_gap++;
      if (sclk && !prev_sclk) begin
        rises++;
        if (cs_n || sess < 2) viol++;
        if (sess == 2) begin
          if (rises == 1 && t <= cfg_rdy) viol++;
          cap2 = {cap2[6:0], mosi};
          rises2 = rises;
        end
        if (sess == 3) begin
          if (rises == 1 && t <= cfg_rd) viol++;
          cap3 = {cap3[14:0], mosi};
          rises3 = rises;
        end
      end
      if (sclk) hi_len++;
      if (!sclk && prev_sclk) begin
        falls++;
        if (hi_len != DIV / 2) bad_hi++;
        hi_len = 0;
      end
      if (cs_n || sess < 2) miso <= 1'b1;
      else if (sess == 2) begin
        if (falls >= 8) begin miso <= (tr < cfg_rst); tr++; end
        else miso <= (t < cfg_rdy);
      end else begin
        if (falls >= 16) miso <= 1'b1;
        else if (falls >= 8) miso <= cfg_ver[15 - falls];
        else miso <= (t < cfg_rd);
      end
      if (!cs_n) t++;
      prev_cs = cs_n;
      prev_sclk = sclk;
    end
  end

  // kind: 0 normal, 1 timeout before command, 2 timeout after command, 3 timeout before read
  task automatic run_one(input int rdy, input int rstd, input int rd, input logic [7:0] ver,
                         input int kind, input bit poke);
    int cyc;
    logic [7:0] v_at;
    logic e_at, cs_at;
    cfg_rdy = rdy; cfg_rst = rstd; cfg_rd = rd; cfg_ver = ver;
    sess = 0; lo1 = 0; hi_gap = 0; viol = 0; bad_hi = 0; rises2 = 0; rises3 = 0;
    cap2 = '0; cap3 = '0; hi_len = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    if (poke) begin
      repeat (50) @(negedge clk);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    cyc = 0;
    while (!done && cyc < 20000) begin
      @(negedge clk);
      cyc++;
    end
    chk(done, "R7", "done seen", int'(done), 1);
    v_at = version; e_at = err; cs_at = cs_n;
    @(negedge clk);
    chk(!done, "R7", "done one cycle", int'(done), 0);
    chk(!busy, "R7", "busy after done", int'(busy), 0);
    chk(cs_at, "R7", "cs_n high at done", int'(cs_at), 1);
    chk(lo1 == exp_cyc(PUS), "R2", "pulse low cycles", lo1, exp_cyc(PUS));
    chk(hi_gap == exp_cyc(HUS), "R2", "hold high cycles", hi_gap, exp_cyc(HUS));
    chk(viol == 0, "R3", "early or ungated sclk edges", viol, 0);
    chk(bad_hi == 0, "R4", "sclk high width errors", bad_hi, 0);
    if (kind == 0) begin
      chk(sess == 3, "R5", "sessions", sess, 3);
      chk(rises2 == 8, "R5", "reset session bits", rises2, 8);
      chk(cap2 == RST, "R5", "reset byte", cap2, RST);
      chk(rises3 == 16, "R6", "read session bits", rises3, 16);
      chk(cap3 == {ADDR | 8'h80, 8'h00}, "R6", "read header+dummy", cap3, {ADDR | 8'h80, 8'h00});
      chk(v_at == ver, "R6", "version", v_at, ver);
      chk(e_at == (ver == 8'hFF), "R8", "err", int'(e_at), int'(ver == 8'hFF));
    end else begin
      chk(sess == (kind == 3 ? 3 : 2), "R9", "sessions after timeout", sess, kind == 3 ? 3 : 2);
      chk((kind == 2 ? rises2 == 8 : (kind == 1 ? rises2 == 0 : rises3 == 0)), "R9",
          "bits in timed-out session", kind == 3 ? rises3 : rises2, kind == 2 ? 8 : 0);
      chk(e_at == 1'b1, "R9", "err on timeout", int'(e_at), 1);
      chk(v_at == 8'hFF, "R9", "version on timeout", v_at, 8'hFF);
    end
    repeat (5) @(negedge clk);
  endtask

  initial begin
    int wd;
    wd = 0;
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 190000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", wd, 190000);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cs_n == 1'b1, "R1", "cs_n in reset", int'(cs_n), 1);
    chk(!sclk && !mosi, "R1", "sclk/mosi in reset", int'({sclk, mosi}), 0);
    chk(!done && !err && !busy, "R1", "flags in reset", int'({done, err, busy}), 0);
    chk(version == 8'h00, "R1", "version in reset", version, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(cs_n && !sclk && !busy, "R1", "idle after reset", int'({cs_n, sclk, busy}), 4);

    // directed corners
    run_one(0, 0, 0, 8'h14, 0, 1'b0);
    run_one(TO - 1, 3, TO - 1, 8'hA5, 0, 1'b0);   // R3 ready on last sample wins
    run_one(TO, 3, 5, 8'h14, 1, 1'b0);            // R3 R9 one sample too late
    run_one(4, 5000, 5, 8'h14, 2, 1'b0);          // R9 reset never completes
    run_one(4, 7, TO, 8'h14, 3, 1'b0);            // R9 read wait too late
    run_one(2, 2, 2, 8'hFF, 0, 1'b0);             // R8 absent slave pattern
    run_one(6, 9, 3, 8'h5A, 0, 1'b1);             // R10 start while busy

    // constrained random
    for (int i = 0; i < 8; i++) begin
      logic [7:0] v;
      v = (i % 4 == 3) ? 8'hFF : 8'($urandom);
      run_one($urandom_range(0, TO - 1), $urandom_range(0, 60),
              $urandom_range(0, TO - 1), v, 0, 1'b0);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule